// File: doc/BRIEF.md
# I2C Controller Status Flags and Clock-Stretch Control

This block keeps the status flags of an I2C controller peripheral. A separate bit-level engine reports bus events to it as single-cycle strobes: a start condition has been generated, a slave address or general call has been recognised, an acknowledge pulse has finished, an address phase has been acknowledged, a stop has been seen, or arbitration has been lost. The engine also reports the current transfer direction. The block also watches the CPU's accesses to the status register and the data register.

From these inputs it keeps four flags: start generated, controller mode, address matched and byte done. It presents them as a status byte. While the byte-done or address-matched flag is set, it asks the engine to hold SCL low. It also raises an interrupt request when any enabled flag is set.

Some flags clear only after a two-step access. The status register is read first, and this arms a latch. A data register access then clears the flag. Which access clears it (read or write) depends on the flag and on the direction of the transfer.

Top module: `i2cs_status_ctrl`

## Requirements
- R1: `status_o` holds start at bit 0, controller mode at bit 1, address matched at bit 2 and byte done at bit 3. All higher bits read 0, and all bits are 0 after reset.
- R2: The address-matched flag sets on `ev_addr_match` or on `ev_gen_call`. It clears on a status read (`sr_rd`).
- R3: The start flag sets on `ev_start_gen`. It clears only on an armed data register write. Neither a status read on its own nor a data register read clears it.
- R4: The byte-done flag sets on `ev_addr_done`. It also sets on `ev_byte_ack` when `dir_tx`=1. When `dir_tx`=0, `ev_byte_ack` sets it only if `ack_en`=1.
- R5: The byte-done flag clears on an armed data register read when `dir_tx`=0, and on an armed data register write when `dir_tx`=1. The other kind of access leaves it set.
- R6: A status read made while the start or byte-done flag is set arms a latch. Any data register access disarms it, but a status read in the same cycle wins and arms it again. A data register access with the latch unarmed clears no flag.
- R7: `scl_hold_o` is 1 exactly when the byte-done or address-matched flag is set.
- R8: The controller-mode flag sets on `sw_start_req`. It clears on `ev_stop` or on `ev_arb_lost`.
- R9: While `periph_en`=0, every flag and the latch are 0 from the next edge on, and `irq_o` is 0 as well.
- R10: `irq_o` equals, one cycle later, `periph_en` AND `irq_en` AND (start OR address matched OR byte done).
- R11: When a set event and a clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 forces all flags to 0 |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| dir_tx | input | 1 | 1 = transmitting, 0 = receiving |
| sw_start_req | input | 1 | Software wrote the start control bit |
| ev_start_gen | input | 1 | Engine generated a start condition |
| ev_addr_match | input | 1 | Received address equals own address |
| ev_gen_call | input | 1 | General call recognised |
| ev_byte_ack | input | 1 | Acknowledge pulse after a data byte done |
| ev_addr_done | input | 1 | Address phase acknowledged and completed |
| ev_stop | input | 1 | Stop condition detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| sr_rd | input | 1 | CPU reads the status register |
| dr_rd | input | 1 | CPU reads the data register |
| dr_wr | input | 1 | CPU writes the data register |
| status_o | output | 8 | Status byte |
| scl_hold_o | output | 1 | Request to hold SCL low |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is the armed-latch path crossed with direction. The byte-done flag must survive a data register access of the wrong kind, and an unarmed access must not clear it. The directed stimulus builds these cases on purpose: it sets the flag, arms the latch, then makes a mismatched access, which must also disarm. A second status read followed by the matching access then clears the flag. After that, a long random phase drives sparse strobes and toggles the enables, and checks every cycle against a behavioural model. This covers same-cycle collisions between set events, status reads and data accesses.

// File: rtl/i2cs_pkg.sv
// Package: shared bit positions and sizes for the I2C status flag block.
// Assumes the status byte layout is fixed by software decoding (start at bit 0).
package i2cs_pkg;
    localparam int NFLAG    = 4;
    localparam int BIT_SB   = 0;
    localparam int BIT_MSL  = 1;
    localparam int BIT_ADSL = 2;
    localparam int BIT_BTF  = 3;
    localparam int NIRQ_SRC = 3;
endpackage

// File: rtl/i2cs_flag_cell.sv
// Module: one status flag register with enable gating and set-over-clear priority.
// Assumes set_i and clr_i are single-cycle qualified strobes from the top.
module i2cs_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Flag state: disable forces 0, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (!en_i)  q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/i2cs_arm_latch.sv
// Module: records that the status register was read while a two-step flag was set.
// Assumes a status read in the same cycle as a data access re-arms the latch.
module i2cs_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sr_rd_i,
    input  logic pend_i,
    input  logic dr_acc_i,
    output logic armed_o
);
    // Arm on qualified status read; any data access disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_o <= 1'b0;
        else if (!en_i)                armed_o <= 1'b0;
        else if (sr_rd_i && pend_i)    armed_o <= 1'b1;
        else if (dr_acc_i)             armed_o <= 1'b0;
    end
endmodule

// File: rtl/i2cs_irq_gen.sv
// Module: registered interrupt request from a vector of flag sources.
// Assumes sources are already registered flags, so output lags them by one cycle.
module i2cs_irq_gen #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            irq_en_i,
    input  logic [NSRC-1:0] src_i,
    output logic            irq_o
);
    // Interrupt register: OR of sources, gated by both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= en_i && irq_en_i && (|src_i);
    end
endmodule

// File: rtl/i2cs_status_ctrl.sv
// Module: I2C status flags, two-step clearing, SCL stretch request and interrupt.
// Assumes all ev_* and CPU access inputs are single-cycle strobes in the clk domain.
module i2cs_status_ctrl
    import i2cs_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              irq_en,
    input  logic              ack_en,
    input  logic              dir_tx,
    input  logic              sw_start_req,
    input  logic              ev_start_gen,
    input  logic              ev_addr_match,
    input  logic              ev_gen_call,
    input  logic              ev_byte_ack,
    input  logic              ev_addr_done,
    input  logic              ev_stop,
    input  logic              ev_arb_lost,
    input  logic              sr_rd,
    input  logic              dr_rd,
    input  logic              dr_wr,
    output logic [STAT_W-1:0] status_o,
    output logic              scl_hold_o,
    output logic              irq_o
);
    localparam int PAD_W = STAT_W - NFLAG;

    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic             armed;
    logic             pend;
    logic             dr_acc;
    logic             btf_clr_acc;

    assign pend        = flag_q[BIT_SB] | flag_q[BIT_BTF];
    assign dr_acc      = dr_rd | dr_wr;
    assign btf_clr_acc = dir_tx ? dr_wr : dr_rd;

    // Set and clear conditions per flag.
    always_comb begin
        flag_set           = '0;
        flag_clr           = '0;
        flag_set[BIT_SB]   = ev_start_gen;
        flag_clr[BIT_SB]   = armed && dr_wr;
        flag_set[BIT_MSL]  = sw_start_req;
        flag_clr[BIT_MSL]  = ev_stop || ev_arb_lost;
        flag_set[BIT_ADSL] = ev_addr_match || ev_gen_call;
        flag_clr[BIT_ADSL] = sr_rd;
        flag_set[BIT_BTF]  = ev_addr_done || (ev_byte_ack && (dir_tx || ack_en));
        flag_clr[BIT_BTF]  = armed && btf_clr_acc;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        i2cs_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (periph_en),
            .set_i (flag_set[g]),
            .clr_i (flag_clr[g]),
            .q_o   (flag_q[g])
        );
    end

    i2cs_arm_latch u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (periph_en),
        .sr_rd_i  (sr_rd),
        .pend_i   (pend),
        .dr_acc_i (dr_acc),
        .armed_o  (armed)
    );

    i2cs_irq_gen #(.NSRC(NIRQ_SRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (periph_en),
        .irq_en_i (irq_en),
        .src_i    ({flag_q[BIT_BTF], flag_q[BIT_ADSL], flag_q[BIT_SB]}),
        .irq_o    (irq_o)
    );

    if (PAD_W > 0) begin : g_pad
        assign status_o = {{PAD_W{1'b0}}, flag_q};
    end else begin : g_nopad
        assign status_o = flag_q[STAT_W-1:0];
    end

    assign scl_hold_o = flag_q[BIT_BTF] | flag_q[BIT_ADSL];
endmodule

// File: rtl/i2cs_status_chk.sv
// Module: assertion checker for i2cs_status_ctrl, attached by bind below.
// Assumes the default 8-bit status width.
module i2cs_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       periph_en,
    input logic       irq_en,
    input logic       ack_en,
    input logic       dir_tx,
    input logic       sw_start_req,
    input logic       ev_start_gen,
    input logic       ev_addr_match,
    input logic       ev_gen_call,
    input logic       ev_byte_ack,
    input logic       ev_addr_done,
    input logic       ev_stop,
    input logic       ev_arb_lost,
    input logic       sr_rd,
    input logic       dr_rd,
    input logic       dr_wr,
    input logic [7:0] status_o,
    input logic       scl_hold_o,
    input logic       irq_o
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:4] == 4'b0);

    p_adsl_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd && !ev_addr_match && !ev_gen_call) |=> !status_o[2]);

    p_sb_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && ev_start_gen) |=> status_o[0]);

    p_sb_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && status_o[0] && !dr_wr) |=> status_o[0]);

    p_hold_btf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> scl_hold_o);

    p_hold_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[3] || status_o[2]) |-> !scl_hold_o);

    p_msl_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_start_req && (ev_stop || ev_arb_lost)) |=> !status_o[1]);

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (status_o == 8'h00 && !irq_o));

    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_o);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && (ev_addr_match || ev_gen_call)) |=> status_o[2]);
endmodule

bind i2cs_status_ctrl i2cs_status_chk u_chk (.*);

// File: tb/i2cs_status_ctrl_tb.sv
`timescale 1ns/1ps
module i2cs_status_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic periph_en = 0, irq_en = 0, ack_en = 0, dir_tx = 0;
    logic sw_start_req = 0, ev_start_gen = 0, ev_addr_match = 0, ev_gen_call = 0;
    logic ev_byte_ack = 0, ev_addr_done = 0, ev_stop = 0, ev_arb_lost = 0;
    logic sr_rd = 0, dr_rd = 0, dr_wr = 0;
    logic [7:0] status_o;
    logic scl_hold_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    bit m_sb, m_msl, m_adsl, m_btf, m_arm, m_irq;

    always #2.5 clk = ~clk;

    i2cs_status_ctrl u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each clock edge.
    always @(posedge clk) begin
        bit sb, msl, adsl, btf, arm, irq, dacc, bclr;
        sb = m_sb; msl = m_msl; adsl = m_adsl; btf = m_btf; arm = m_arm;
        irq = periph_en && irq_en && (m_sb || m_adsl || m_btf);
        if (!rst_n || !periph_en) begin
            sb = 0; msl = 0; adsl = 0; btf = 0; arm = 0;
            if (!rst_n) irq = 0;
        end else begin
            dacc = dr_rd || dr_wr;
            bclr = dir_tx ? dr_wr : dr_rd;
            if (m_arm && dr_wr) sb = 0;
            if (ev_start_gen) sb = 1;
            if (ev_stop || ev_arb_lost) msl = 0;
            if (sw_start_req) msl = 1;
            if (sr_rd) adsl = 0;
            if (ev_addr_match || ev_gen_call) adsl = 1;
            if (m_arm && bclr) btf = 0;
            if (ev_addr_done || (ev_byte_ack && (dir_tx || ack_en))) btf = 1;
            if (dacc) arm = 0;
            if (sr_rd && (m_sb || m_btf)) arm = 1;
        end
        m_sb <= sb; m_msl <= msl; m_adsl <= adsl; m_btf <= btf;
        m_arm <= arm; m_irq <= irq;
    end

    // Compare outputs to the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 start bit", status_o[0], m_sb);
            chk("R8 mode bit", status_o[1], m_msl);
            chk("R2 addr bit", status_o[2], m_adsl);
            chk("R5 byte-done bit", status_o[3], m_btf);
            chk("R1 upper bits", status_o[7:4], 0);
            chk("R7 scl hold", scl_hold_o, m_btf || m_adsl);
            chk("R10 irq", irq_o, m_irq);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        sw_start_req = 0; ev_start_gen = 0; ev_addr_match = 0; ev_gen_call = 0;
        ev_byte_ack = 0; ev_addr_done = 0; ev_stop = 0; ev_arb_lost = 0;
        sr_rd = 0; dr_rd = 0; dr_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", status_o, 0);
        rst_n = 1;
        periph_en = 1; irq_en = 1; ack_en = 1;
        tick();
        // R8 start request sets mode
        sw_start_req = 1; tick();
        chk("R8 mode set", status_o[1], 1);
        // R3 start flag
        ev_start_gen = 1; tick();
        chk("R3 start set", status_o[0], 1);
        tick();
        chk("R10 irq follows", irq_o, 1);
        // R6 unarmed write has no effect
        dr_wr = 1; tick();
        chk("R6 unarmed write", status_o[0], 1);
        sr_rd = 1; tick();
        dr_rd = 1; tick();
        chk("R3 read keeps start", status_o[0], 1);
        dr_wr = 1; tick();
        chk("R6 disarmed by read", status_o[0], 1);
        sr_rd = 1; tick();
        dr_wr = 1; tick();
        chk("R3 armed write clears", status_o[0], 0);
        // R4 address phase done, transmit
        dir_tx = 1; ev_addr_done = 1; tick();
        chk("R4 addr done sets", status_o[3], 1);
        chk("R7 hold with byte done", scl_hold_o, 1);
        sr_rd = 1; tick();
        dr_rd = 1; tick();
        chk("R5 wrong access keeps", status_o[3], 1);
        sr_rd = 1; tick();
        dr_wr = 1; tick();
        chk("R5 tx write clears", status_o[3], 0);
        // R4 receive with ack disabled, then enabled
        dir_tx = 0; ack_en = 0; ev_byte_ack = 1; tick();
        chk("R4 rx no ack", status_o[3], 0);
        ack_en = 1; ev_byte_ack = 1; tick();
        chk("R4 rx ack sets", status_o[3], 1);
        sr_rd = 1; tick();
        dr_rd = 1; tick();
        chk("R5 rx read clears", status_o[3], 0);
        // R2 general call, R11 collision
        ev_gen_call = 1; tick();
        chk("R2 general call sets", status_o[2], 1);
        sr_rd = 1; ev_addr_match = 1; tick();
        chk("R11 set wins", status_o[2], 1);
        sr_rd = 1; tick();
        chk("R2 status read clears", status_o[2], 0);
        chk("R7 hold released", scl_hold_o, 0);
        // R8 arbitration loss
        ev_arb_lost = 1; tick();
        chk("R8 arb lost clears", status_o[1], 0);
        // R9 disable forces zero
        ev_start_gen = 1; ev_addr_match = 1; sw_start_req = 1; tick();
        periph_en = 0; tick();
        chk("R9 disabled status", status_o, 0);
        chk("R9 disabled irq", irq_o, 0);
        periph_en = 1; irq_en = 0;
        ev_start_gen = 1; tick(); tick();
        chk("R10 masked irq", irq_o, 0);
        irq_en = 1;
        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            periph_en    = ($urandom_range(0, 49) != 0);
            irq_en       = ($urandom_range(0, 7) != 0);
            ack_en       = $urandom_range(0, 1);
            dir_tx       = $urandom_range(0, 1);
            sw_start_req = ($urandom_range(0, 9) == 0);
            ev_start_gen = ($urandom_range(0, 7) == 0);
            ev_addr_match= ($urandom_range(0, 9) == 0);
            ev_gen_call  = ($urandom_range(0, 19) == 0);
            ev_byte_ack  = ($urandom_range(0, 5) == 0);
            ev_addr_done = ($urandom_range(0, 11) == 0);
            ev_stop      = ($urandom_range(0, 11) == 0);
            ev_arb_lost  = ($urandom_range(0, 19) == 0);
            sr_rd        = ($urandom_range(0, 3) == 0);
            dr_rd        = ($urandom_range(0, 4) == 0);
            dr_wr        = ($urandom_range(0, 4) == 0);
            tick();
        end
        finish_run();
    end
endmodule